// File: doc/BRIEF.md
# Interrupt Redirection Unit with Indirect Register Access

This unit gathers a set of I/O interrupt input pins. Each pin has one 64-bit redirection entry. The entry picks the vector, the delivery mode, the destination and its addressing mode, the polarity and the trigger style for that pin. Software reaches the unit through two 32-bit locations only. A select register names an internal register, and a data window reads or writes whatever the select register names. Each 64-bit entry therefore appears as two consecutive selections, one for each 32-bit half.

Every pin keeps a request bit and a "due" marker. A pin that triggers on edges latches a request when its input rises, and that request is consumed when the pin's message is issued. A pin that triggers on levels keeps a request that tracks its input. That request survives message issue, so any later entry write sends the message again while the input stays high. A masked pin issues nothing but keeps its request. A single scan picks the lowest-numbered pending unmasked pin and places its message in an output register. The output register is drained through a valid/ready handshake.

Top module: `pin_irq_router`

## Requirements
- R1: Offset 0x00 reads and writes the 8-bit select register, and its bits 31:8 read as zero. Offset 0x10 is the data window onto the selected register. Any other offset reads zero and ignores writes.
- R2: Selection 0x00 holds the unit ID in bits 31:24, and the other bits read as zero. Selection 0x01 reads 0x00170011 by default: 0x11 in bits 7:0 and the pin count minus one in bits 23:16. Selection 0x02 reads zero. Writes to 0x01 and 0x02 change nothing.
- R3: For pin n, selection 0x10+2n maps to entry bits 31:0 and selection 0x11+2n maps to entry bits 63:32. A write to one half leaves the other half unchanged, and both halves read back as written.
- R4: Selections above the last entry half (above 0x3F by default) read zero and ignore writes.
- R5: After reset, every entry holds 0x0000000000010000, the ID and the select register are zero, and no message is valid.
- R6: For a pin with bit 15 clear (edge trigger), a rising input causes exactly one message. The request is consumed when that message is issued. Holding the input high does not issue another message, and neither does a later entry write.
- R7: For a pin with bit 15 set (level trigger), a rising input issues a message. While the input stays high, each entry write issues the message again. Once the input is low, an entry write issues nothing.
- R8: A pin with bit 16 set (masked) issues nothing but keeps its pending request. An entry write that clears the mask then issues the message.
- R9: Message fields come from the entry of the pin being served: vector from bits 7:0, delivery mode from 10:8, destination mode from 11, polarity from 13, trigger from 15 and destination from 63:56. The pin number is given as well.
- R10: When several pins are pending, their messages leave in ascending pin order.
- R11: While msg_valid is high and msg_ready is low, the message stays valid and every field stays stable. At most one message is accepted per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Register offset (0x00 select, 0x10 window) |
| reg_wr | input | 1 | Write strobe, taken on the rising clock edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr and state |
| irq_in | input | NUM_PINS | Interrupt input pins, active high |
| msg_valid | output | 1 | A delivery message is presented |
| msg_ready | input | 1 | The receiver accepts the message this cycle |
| msg_pin | output | PIN_W | Pin whose message is presented |
| msg_dest | output | 8 | Destination field |
| msg_dest_mode | output | 1 | Destination addressing mode |
| msg_mode | output | 3 | Delivery mode |
| msg_vector | output | 8 | Interrupt vector |
| msg_polarity | output | 1 | Input polarity field |
| msg_level | output | 1 | Trigger field, 1 = level |

## Verification
The bench builds the unit with its default values: 24 pins and identification byte 0x11. With these values, selection 0x3F is the last valid entry half and selection 0x40 is the first selection past the table. The bench exercises both, and it also checks that the pin-count field reads 23. Randomly chosen pins and field values cover every pin's entry slot and every message field. Directed cases cover the behaviours that differ between pin types: edge against level re-issue, a masked request that survives until the mask clears, three pins pending at once, and a stalled handshake.

// File: rtl/pin_irq_router.sv
module pin_irq_router #(
  parameter int NUM_PINS = 24,
  parameter logic [7:0] VERSION = 8'h11,
  localparam int PIN_W = $clog2(NUM_PINS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [7:0]          reg_addr,
  input  logic                reg_wr,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  input  logic [NUM_PINS-1:0] irq_in,
  output logic                msg_valid,
  input  logic                msg_ready,
  output logic [PIN_W-1:0]    msg_pin,
  output logic [7:0]          msg_dest,
  output logic                msg_dest_mode,
  output logic [2:0]          msg_mode,
  output logic [7:0]          msg_vector,
  output logic                msg_polarity,
  output logic                msg_level
);

  localparam logic [7:0]  SEL_OFF  = 8'h00;
  localparam logic [7:0]  WIN_OFF  = 8'h10;
  localparam logic [7:0]  TAB_BASE = 8'h10;
  localparam logic [63:0] ENT_RST  = 64'h0000_0000_0001_0000;

  logic [7:0]  idx_q, id_q;
  logic [63:0] ent_q [NUM_PINS];
  logic [NUM_PINS-1:0] irq_q, req_q, due_q, lvl, msk, elig, take, rise;
  logic [7:0]  win_off;
  logic        tab_hit, wr_sel, wr_win, ent_wr, load;
  logic [PIN_W-1:0] tab_pin, pick;

  assign wr_sel  = reg_wr && (reg_addr == SEL_OFF);
  assign wr_win  = reg_wr && (reg_addr == WIN_OFF);
  assign win_off = idx_q - TAB_BASE;
  assign tab_hit = (idx_q >= TAB_BASE) && (win_off[7:1] < 7'(NUM_PINS));
  assign tab_pin = win_off[PIN_W:1];
  assign ent_wr  = wr_win && tab_hit;
  assign rise    = irq_in & ~irq_q;
  assign elig    = due_q & ~msk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      id_q  <= '0;
      irq_q <= '0;
    end else begin
      irq_q <= irq_in;
      if (wr_sel) idx_q <= reg_wdata[7:0];
      if (wr_win && idx_q == 8'h00) id_q <= reg_wdata[31:24];
    end
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic req_nx, due_nx;

    assign lvl[i]  = ent_q[i][15];
    assign msk[i]  = ent_q[i][16];
    assign take[i] = load && (pick == PIN_W'(i));
    assign req_nx  = lvl[i] ? irq_in[i] : ((req_q[i] & ~take[i]) | rise[i]);
    assign due_nx  = ((due_q[i] & ~take[i]) | rise[i] | (ent_wr & req_q[i])) & req_nx;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_q[i] <= ENT_RST;
        req_q[i] <= 1'b0;
        due_q[i] <= 1'b0;
      end else begin
        req_q[i] <= req_nx;
        due_q[i] <= due_nx;
        if (ent_wr && tab_pin == PIN_W'(i)) begin
          if (idx_q[0]) ent_q[i][63:32] <= reg_wdata;
          else          ent_q[i][31:0]  <= reg_wdata;
        end
      end
    end
  end

  always_comb begin
    pick = '0;
    for (int i = NUM_PINS - 1; i >= 0; i--)
      if (elig[i]) pick = PIN_W'(i);
  end

  assign load = (|elig) && (!msg_valid || msg_ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msg_valid     <= 1'b0;
      msg_pin       <= '0;
      msg_dest      <= '0;
      msg_dest_mode <= 1'b0;
      msg_mode      <= '0;
      msg_vector    <= '0;
      msg_polarity  <= 1'b0;
      msg_level     <= 1'b0;
    end else if (load) begin
      msg_valid     <= 1'b1;
      msg_pin       <= pick;
      msg_dest      <= ent_q[pick][63:56];
      msg_dest_mode <= ent_q[pick][11];
      msg_mode      <= ent_q[pick][10:8];
      msg_vector    <= ent_q[pick][7:0];
      msg_polarity  <= ent_q[pick][13];
      msg_level     <= ent_q[pick][15];
    end else if (msg_ready) begin
      msg_valid     <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == SEL_OFF) begin
      reg_rdata = {24'd0, idx_q};
    end else if (reg_addr == WIN_OFF) begin
      if (idx_q == 8'h00)      reg_rdata = {id_q, 24'd0};
      else if (idx_q == 8'h01) reg_rdata = {8'd0, 8'(NUM_PINS - 1), 8'd0, VERSION};
      else if (tab_hit)        reg_rdata = idx_q[0] ? ent_q[tab_pin][63:32] : ent_q[tab_pin][31:0];
    end
  end

endmodule

module pin_irq_router_chk #(
  parameter int NUM_PINS = 24,
  localparam int PIN_W = $clog2(NUM_PINS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [7:0]       reg_addr,
  input logic [31:0]      reg_rdata,
  input logic             msg_valid,
  input logic             msg_ready,
  input logic [PIN_W-1:0] msg_pin,
  input logic [7:0]       msg_dest,
  input logic             msg_dest_mode,
  input logic [2:0]       msg_mode,
  input logic [7:0]       msg_vector,
  input logic             msg_polarity,
  input logic             msg_level
);

  // R11
  msg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable({msg_pin, msg_dest, msg_dest_mode,
                                                         msg_mode, msg_vector, msg_polarity, msg_level})));

  // R1
  other_off_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr != 8'h00 && reg_addr != 8'h10) |-> (reg_rdata == 32'd0));

  // R1
  sel_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 8'h00) |-> (reg_rdata[31:8] == 24'd0));

  // R5
  reset_idle_chk: assert property (@(posedge clk) !rst_n |=> !msg_valid);

  // R9
  pin_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> (32'(msg_pin) < NUM_PINS));

endmodule

bind pin_irq_router pin_irq_router_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
  .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_pin(msg_pin),
  .msg_dest(msg_dest), .msg_dest_mode(msg_dest_mode), .msg_mode(msg_mode),
  .msg_vector(msg_vector), .msg_polarity(msg_polarity), .msg_level(msg_level)
);

// File: tb/sim_pin_irq_router.sv
`timescale 1ns/1ps
module sim_pin_irq_router;
  localparam int NP = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] reg_addr = '0;
  logic reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [NP-1:0] irq_in = '0;
  logic msg_valid, msg_ready = 1'b0;
  logic [4:0] msg_pin;
  logic [7:0] msg_dest, msg_vector;
  logic msg_dest_mode, msg_polarity, msg_level;
  logic [2:0] msg_mode;

  pin_irq_router u0 (.*);

  always #2.5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  logic [63:0] sh [NP];
  bit got;
  logic [4:0] gpin;
  logic [23:0] gword;
  logic [31:0] rv;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] exp_msg(input logic [63:0] e);
    return {e[63:56], e[11], e[10:8], e[7:0], e[13], e[15]};
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wr = 1'b0;
    #1 d = reg_rdata;
  endtask

  task automatic wr_ent(input int p, input bit hi, input logic [31:0] d);
    wr(8'h00, 8'(8'h10 + 2 * p + int'(hi)));
    wr(8'h10, d);
    if (p < NP) begin
      if (hi) sh[p][63:32] = d; else sh[p][31:0] = d;
    end
  endtask

  task automatic rd_ent(input int p, input bit hi, output logic [31:0] d);
    wr(8'h00, 8'(8'h10 + 2 * p + int'(hi)));
    rd(8'h10, d);
  endtask

  task automatic take_msg(input int max_cyc);
    got = 1'b0;
    @(negedge clk); msg_ready = 1'b1;
    for (int k = 0; k < max_cyc; k++) begin
      if (msg_valid) begin
        got = 1'b1;
        gpin = msg_pin;
        gword = {msg_dest, msg_dest_mode, msg_mode, msg_vector, msg_polarity, msg_level};
        break;
      end
      @(negedge clk);
    end
    @(negedge clk); msg_ready = 1'b0;
  endtask

  task automatic expect_none(input int cyc, input string tag);
    bit seen = 1'b0;
    @(negedge clk); msg_ready = 1'b1;
    for (int k = 0; k < cyc; k++) begin
      if (msg_valid) seen = 1'b1;
      @(negedge clk);
    end
    msg_ready = 1'b0;
    chk(!seen, tag, seen, 0);
  endtask

  task automatic pulse(input int p);
    @(negedge clk); irq_in[p] = 1'b1;
    repeat (2) @(negedge clk);
    irq_in[p] = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R11 actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] lo, hi, v;
    int p;
    for (int i = 0; i < NP; i++) sh[i] = 64'h1_0000;
    void'($urandom(32'd4711));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R5 reset state
    chk(!msg_valid, "R5 msg_valid after reset", msg_valid, 0);
    rd(8'h00, rv); chk(rv == 0, "R5 select reg reset", rv, 0);
    rd(8'h10, rv); chk(rv == 0, "R5 ID reset", rv, 0);
    for (int i = 0; i < NP; i++) begin
      rd_ent(i, 0, lo); rd_ent(i, 1, hi);
      chk({hi, lo} == 64'h1_0000, "R5 entry reset value", {hi, lo}, 64'h1_0000);
    end

    // R1 select reg readback and other offsets
    wr(8'h00, 32'hFFFF_FF02);
    rd(8'h00, rv); chk(rv == 32'h02, "R1 select reg upper bits zero", rv, 32'h02);
    wr(8'h20, 32'h5555_5555);
    rd(8'h20, rv); chk(rv == 0, "R1 other offset reads zero", rv, 0);
    rd(8'h00, rv); chk(rv == 32'h02, "R1 other offset write ignored", rv, 32'h02);

    // R2 ID, version, reserved
    wr(8'h00, 32'h00); wr(8'h10, 32'hAB12_3456);
    rd(8'h10, rv); chk(rv == 32'hAB00_0000, "R2 ID field", rv, 32'hAB00_0000);
    wr(8'h00, 32'h01);
    rd(8'h10, rv); chk(rv == 32'h0017_0011, "R2 version word", rv, 32'h0017_0011);
    wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h10, rv); chk(rv == 32'h0017_0011, "R2 version write ignored", rv, 32'h0017_0011);
    wr(8'h00, 32'h02); wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h10, rv); chk(rv == 0, "R2 selection 0x02 reads zero", rv, 0);

    // R4 past the table
    wr(8'h00, 32'h40); wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h10, rv); chk(rv == 0, "R4 selection 0x40 reads zero", rv, 0);
    rd_ent(23, 0, lo); rd_ent(23, 1, hi);
    chk({hi, lo} == sh[23], "R4 last entry untouched", {hi, lo}, sh[23]);

    // R3 half writes keep the other half
    for (int k = 0; k < 12; k++) begin
      p = $urandom_range(0, NP - 1);
      v = $urandom; v[16] = 1'b1;
      wr_ent(p, 1, $urandom);
      wr_ent(p, 0, v);
      wr_ent(p, 1, $urandom);
      rd_ent(p, 0, lo); rd_ent(p, 1, hi);
      chk({hi, lo} == sh[p], "R3 entry halves readback", {hi, lo}, sh[p]);
    end
    for (int i = 0; i < NP; i++) begin wr_ent(i, 0, 32'h1_0000); wr_ent(i, 1, 0); end

    // R6 edge pin held high
    wr_ent(5, 1, 32'hA500_0000);
    wr_ent(5, 0, 32'h0000_2B35);
    @(negedge clk); irq_in[5] = 1'b1;
    take_msg(20);
    chk(got && gpin == 5, "R6 edge pin message issued", {got, gpin}, {1'b1, 5'd5});
    chk(gword == exp_msg(sh[5]), "R9 edge message fields", gword, exp_msg(sh[5]));
    expect_none(10, "R6 edge held high not reissued");
    wr_ent(5, 1, 32'hA500_0000);
    expect_none(10, "R6 edge entry write not reissued");
    irq_in[5] = 1'b0;
    wr_ent(5, 0, 32'h1_0000);

    // R7 level pin
    wr_ent(7, 1, 32'hC300_0000);
    wr_ent(7, 0, 32'h0000_AA47);
    @(negedge clk); irq_in[7] = 1'b1;
    take_msg(20);
    chk(got && gpin == 7, "R7 level pin message issued", {got, gpin}, {1'b1, 5'd7});
    chk(gword == exp_msg(sh[7]), "R9 level message fields", gword, exp_msg(sh[7]));
    expect_none(10, "R7 level held high not resent without write");
    wr_ent(7, 1, 32'hC300_0000);
    take_msg(20);
    chk(got && gpin == 7, "R7 level reissued after entry write", {got, gpin}, {1'b1, 5'd7});
    @(negedge clk); irq_in[7] = 1'b0;
    repeat (3) @(negedge clk);
    wr_ent(7, 1, 32'hC300_0000);
    expect_none(10, "R7 level low no message on write");
    wr_ent(7, 0, 32'h1_0000);

    // R8 masked pin
    wr_ent(9, 1, 32'h1100_0000);
    wr_ent(9, 0, 32'h0001_0059);
    pulse(9);
    expect_none(10, "R8 masked pin silent");
    wr_ent(9, 0, 32'h0000_0059);
    take_msg(20);
    chk(got && gpin == 9, "R8 unmask releases kept request", {got, gpin}, {1'b1, 5'd9});
    chk(gword == exp_msg(sh[9]), "R9 unmasked message fields", gword, exp_msg(sh[9]));
    wr_ent(9, 0, 32'h1_0000);

    // R10 ordering, R11 stall
    wr_ent(20, 0, 32'h0000_0014); wr_ent(2, 0, 32'h0000_0002); wr_ent(10, 0, 32'h0000_000A);
    @(negedge clk); irq_in[20] = 1'b1; irq_in[2] = 1'b1; irq_in[10] = 1'b1;
    repeat (4) @(negedge clk);
    irq_in = '0;
    chk(msg_valid && msg_pin == 2, "R11 stalled message presented", {msg_valid, msg_pin}, {1'b1, 5'd2});
    repeat (5) @(negedge clk);
    chk(msg_valid && msg_pin == 2 && msg_vector == 8'h02, "R11 stalled message stable",
        {msg_valid, msg_pin, msg_vector}, {1'b1, 5'd2, 8'h02});
    take_msg(5);  chk(got && gpin == 2,  "R10 first pin 2",   gpin, 2);
    take_msg(10); chk(got && gpin == 10, "R10 second pin 10", gpin, 10);
    take_msg(10); chk(got && gpin == 20, "R10 third pin 20",  gpin, 20);
    wr_ent(2, 0, 32'h1_0000); wr_ent(10, 0, 32'h1_0000); wr_ent(20, 0, 32'h1_0000);

    // R9 random pins and fields
    for (int k = 0; k < 40; k++) begin
      p = $urandom_range(0, NP - 1);
      lo = $urandom; lo[16] = 1'b0; lo[15] = 1'b0;
      wr_ent(p, 1, $urandom);
      wr_ent(p, 0, lo);
      pulse(p);
      take_msg(20);
      chk(got && gpin == 5'(p), "R9 random pin number", {got, gpin}, {1'b1, 5'(p)});
      chk(gword == exp_msg(sh[p]), "R9 random message fields", gword, exp_msg(sh[p]));
      wr_ent(p, 0, lo | 32'h1_0000);
    end

    finish_run();
  end
endmodule